// File: doc/BRIEF.md
# I2S receive word formatter

This block sits behind the serial data and word-select lines of an I2S receiver and turns each incoming serial word into a 32-bit receive word. It handles eight word lengths and either bit order. It places the word at a fixed alignment point in the 32-bit register, and it can sign-extend words that sit at the low end. Every completed word is pushed into the receive FIFO of the channel that the word-select level names. A per-channel ready flag, and an interrupt line gated by per-channel enables, tell the consumer when to read.

The block runs on the bit clock, and one serial bit is sampled at every rising edge. A word starts in the cycle in which word-select differs from its value in the previous cycle. A one-cycle write strobe loads the configuration, which only a power-on reset clears. A synchronous soft reset empties the FIFOs and abandons a word in progress, but leaves the configuration alone. The consumer reads through a single port: it selects a channel and pulses a read enable.

Top module: `i2s_rx_fmt`

## Requirements
- R1: The 3-bit word-length code selects the word length: 0 gives 8 bits, 1 gives 10, 2 gives 12, 3 gives 16, 4 gives 18, 5 gives 20, 6 gives 22 and 7 gives 24.
- R2: With `cfg_lsb_first`=0 the first bit received becomes the word's most significant bit. With `cfg_lsb_first`=1 the first bit received becomes bit 0 of the word.
- R3: With `cfg_lsb_align`=0 and a word length of 16 to 24 bits, the word's top bit lands on bit 31 and every bit below the word is zero.
- R4: With `cfg_lsb_align`=0 and a word length of 8, 10 or 12 bits, the word's top bit lands on bit 15 and all other bits are zero.
- R5: With `cfg_lsb_align`=1 the word occupies bits 0 upward. When `cfg_sign_ext`=0 the bits above the word are zero.
- R6: With `cfg_lsb_align`=1 and `cfg_sign_ext`=1, the bits above the word copy the word's top bit. With `cfg_lsb_align`=0, `cfg_sign_ext` has no effect.
- R7: A word starts in the cycle in which `ws` differs from its previous value, and the word belongs to channel `ws` (0 or 1). Bits that arrive after the word length is reached are ignored. A change of `ws` before the word is complete drops the partial word.
- R8: With its FIFO enabled, a channel holds up to FIFO_DEPTH (16) words. Its ready flag is set in the cycle after the stored count reaches FIFO_DEPTH-1 (15). A word that arrives while the FIFO is full is discarded.
- R9: With its FIFO disabled, a channel holds one word. Its ready flag is set two clock edges after the word's last bit is sampled. A newer word replaces an unread one.
- R10: `rd_data` shows the oldest word of channel `rd_ch`, or zero when that channel is empty. `rd_en` removes that word. A removal that takes the count below the threshold clears the ready flag at that same clock edge.
- R11: `irq` is high whenever a channel's ready flag and that channel's interrupt enable are both set.
- R12: The configuration is loaded on `cfg_we` and cleared by `por_n`. `soft_rst` does not change it, but it empties both FIFOs, clears the ready flags and drops any word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous block reset; configuration kept |
| cfg_we | input | 1 | Loads all configuration inputs |
| cfg_wl_code | input | 3 | Word-length code (R1) |
| cfg_lsb_first | input | 1 | Serial bit order, 1 = least significant first |
| cfg_lsb_align | input | 1 | 1 = word placed from bit 0, 0 = top aligned |
| cfg_sign_ext | input | 1 | Sign extension for low-aligned words |
| cfg_fifo_en | input | NUM_CH | Per-channel FIFO enable |
| cfg_irq_en | input | NUM_CH | Per-channel interrupt enable |
| ws | input | 1 | Word select; its level names the channel |
| sd | input | 1 | Serial data |
| rd_en | input | 1 | Removes the head word of channel rd_ch |
| rd_ch | input | $clog2(NUM_CH) | Channel selected for reading |
| rd_data | output | 32 | Head word of the selected channel, zero if empty |
| ready | output | NUM_CH | Per-channel data-ready flags |
| irq | output | 1 | Receive interrupt |

## Verification
A wrong bit counter or wrong shift direction shows up on `rd_data` two edges after the word's last bit: the word is misplaced, bit-reversed or carries stray upper bits. Each stimulus vector pins one combination of length, order, alignment and sign extension against a computed 32-bit value. A wrong FIFO count shows up as a ready flag that rises one word early or late, or fails to fall on the read that crosses 15. It also shows up as a word that should have been dropped being read back. The bench therefore samples `ready` after every write near the threshold and after every read. A configuration register that a soft reset disturbs shows up in the formatting of the first word after that reset.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;

   localparam int REG_W   = 32;
   localparam int MAX_WL  = 24;
   localparam int WL_W    = $clog2(MAX_WL + 1);
   localparam int CODE_W  = 3;

   typedef struct packed {
      logic [CODE_W-1:0] wl_code;
      logic              lsb_first;
      logic              lsb_align;
      logic              sign_ext;
   } fmt_cfg_t;

   // Map the word-length code to a bit count.
   function automatic logic [WL_W-1:0] wl_bits(input logic [CODE_W-1:0] code);
      logic [WL_W-1:0] n;
      case (code)
         3'd0:    n = WL_W'(8);
         3'd1:    n = WL_W'(10);
         3'd2:    n = WL_W'(12);
         3'd3:    n = WL_W'(16);
         3'd4:    n = WL_W'(18);
         3'd5:    n = WL_W'(20);
         3'd6:    n = WL_W'(22);
         default: n = WL_W'(24);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/i2s_rx_deser.sv
`timescale 1ns/1ps
module i2s_rx_deser
   import i2s_rx_pkg::*;
#(
   parameter int WORD_MAX = MAX_WL,
   parameter int CNT_W    = WL_W
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                soft_rst,
   input  logic                ws,
   input  logic                sd,
   input  logic [CNT_W-1:0]    wl,
   input  logic                lsb_first,
   output logic                word_vld,
   output logic                word_ch,
   output logic [WORD_MAX-1:0] word_raw
);

   logic                prev_ws;
   logic                busy;
   logic                ch_q;
   logic [CNT_W-1:0]    cnt;
   logic [WORD_MAX-1:0] sh;

   logic                start;
   logic                take;
   logic                fin;
   logic [CNT_W-1:0]    cnt_cur;
   logic [CNT_W-1:0]    cnt_nx;
   logic [WORD_MAX-1:0] base;
   logic [WORD_MAX-1:0] sh_nx;

   always_comb begin
      start   = ws ^ prev_ws;
      take    = start | busy;
      base    = start ? '0 : sh;
      cnt_cur = start ? '0 : cnt;
      cnt_nx  = cnt_cur + CNT_W'(1);
      if (lsb_first)
         sh_nx = (base >> 1) | (WORD_MAX'(sd) << (wl - CNT_W'(1)));
      else
         sh_nx = {base[WORD_MAX-2:0], sd};
      fin     = take && (cnt_nx == wl);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         prev_ws  <= 1'b0;
         busy     <= 1'b0;
         ch_q     <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
         word_vld <= 1'b0;
         word_ch  <= 1'b0;
         word_raw <= '0;
      end else if (soft_rst) begin
         prev_ws  <= 1'b0;
         busy     <= 1'b0;
         ch_q     <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
         word_vld <= 1'b0;
      end else begin
         prev_ws  <= ws;
         word_vld <= fin;
         if (start)
            ch_q <= ws;
         if (take) begin
            sh   <= sh_nx;
            cnt  <= cnt_nx;
            busy <= !fin;
         end
         if (fin) begin
            word_raw <= sh_nx;
            word_ch  <= start ? ws : ch_q;
         end
      end
   end

endmodule

// File: rtl/i2s_rx_align.sv
`timescale 1ns/1ps
module i2s_rx_align
   import i2s_rx_pkg::*;
#(
   parameter int WORD_MAX = MAX_WL,
   parameter int CNT_W    = WL_W,
   parameter int OUT_W    = REG_W
) (
   input  logic [WORD_MAX-1:0] raw,
   input  logic [CNT_W-1:0]    wl,
   input  logic                lsb_align,
   input  logic                sign_ext,
   output logic [OUT_W-1:0]    word
);

   localparam int HALF_W = OUT_W / 2;

   logic [OUT_W-1:0] mask;
   logic [OUT_W-1:0] val;
   logic             top;

   always_comb begin
      mask = (OUT_W'(1) << wl) - OUT_W'(1);
      val  = {{(OUT_W-WORD_MAX){1'b0}}, raw} & mask;
      top  = val[wl - CNT_W'(1)];
      if (lsb_align)
         word = (sign_ext && top) ? (val | ~mask) : val;
      else if (wl >= CNT_W'(HALF_W))
         word = val << (OUT_W'(OUT_W) - OUT_W'(wl));
      else
         word = val << (OUT_W'(HALF_W) - OUT_W'(wl));
   end

endmodule

// File: rtl/i2s_rx_chan_fifo.sv
`timescale 1ns/1ps
module i2s_rx_chan_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_rst,
   input  logic              en,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     level,
   output logic              ready
);

   localparam int READY_LEVEL = DEPTH - 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp;
   logic [AW-1:0]     rp;

   logic              pop;
   logic              wr;
   logic [AW-1:0]     wa;
   logic [CW-1:0]     level_nx;
   logic [CW-1:0]     thr;

   always_comb begin
      pop = pop_req && (level != '0);
      if (en) begin
         wr       = push && (level != CW'(DEPTH));
         wa       = wp;
         level_nx = level + CW'(wr) - CW'(pop);
         thr      = CW'(READY_LEVEL);
      end else begin
         wr       = push;
         wa       = rp;
         level_nx = push ? CW'(1) : (pop ? '0 : level);
         thr      = CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr)
         mem[wa] <= push_data;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
         ready <= 1'b0;
      end else if (soft_rst) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
         ready <= 1'b0;
      end else begin
         if (en && wr)
            wp <= wp + AW'(1);
         if (en && pop)
            rp <= rp + AW'(1);
         level <= level_nx;
         ready <= (level_nx >= thr);
      end
   end

   assign head = (level != '0) ? mem[rp] : '0;

endmodule

// File: rtl/i2s_rx_fmt.sv
`timescale 1ns/1ps
module i2s_rx_fmt
   import i2s_rx_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int FIFO_DEPTH = 16,
   localparam int CH_W      = $clog2(NUM_CH),
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 soft_rst,
   input  logic                 cfg_we,
   input  logic [CODE_W-1:0]    cfg_wl_code,
   input  logic                 cfg_lsb_first,
   input  logic                 cfg_lsb_align,
   input  logic                 cfg_sign_ext,
   input  logic [NUM_CH-1:0]    cfg_fifo_en,
   input  logic [NUM_CH-1:0]    cfg_irq_en,
   input  logic                 ws,
   input  logic                 sd,
   input  logic                 rd_en,
   input  logic [CH_W-1:0]      rd_ch,
   output logic [REG_W-1:0]     rd_data,
   output logic [NUM_CH-1:0]    ready,
   output logic                 irq
);

   // Elaboration-time parameter checks
   if (NUM_CH != 2) begin : g_bad_ch
      $error("i2s_rx_fmt: word select carries exactly two channels");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("i2s_rx_fmt: FIFO_DEPTH must be a power of two, at least 2");
   end

   fmt_cfg_t                     fmt_q;
   logic [NUM_CH-1:0]            fifo_en_q;
   logic [NUM_CH-1:0]            irq_en_q;

   logic [WL_W-1:0]              wl;
   logic                         word_vld;
   logic                         word_ch;
   logic [MAX_WL-1:0]            word_raw;
   logic [REG_W-1:0]             word_fmt;

   logic [NUM_CH-1:0]            push_v;
   logic [NUM_CH-1:0]            pop_v;
   logic [NUM_CH-1:0][REG_W-1:0] head_v;
   logic [NUM_CH-1:0][CNT_W-1:0] level_v;

   // Configuration: cleared by power-on reset only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         fmt_q     <= '0;
         fifo_en_q <= '0;
         irq_en_q  <= '0;
      end else if (cfg_we) begin
         fmt_q     <= '{wl_code:   cfg_wl_code,
                        lsb_first: cfg_lsb_first,
                        lsb_align: cfg_lsb_align,
                        sign_ext:  cfg_sign_ext};
         fifo_en_q <= cfg_fifo_en;
         irq_en_q  <= cfg_irq_en;
      end
   end

   assign wl = wl_bits(fmt_q.wl_code);

   i2s_rx_deser #(.WORD_MAX(MAX_WL), .CNT_W(WL_W)) deser_i (
      .clk       (clk),
      .por_n     (por_n),
      .soft_rst  (soft_rst),
      .ws        (ws),
      .sd        (sd),
      .wl        (wl),
      .lsb_first (fmt_q.lsb_first),
      .word_vld  (word_vld),
      .word_ch   (word_ch),
      .word_raw  (word_raw)
   );

   i2s_rx_align #(.WORD_MAX(MAX_WL), .CNT_W(WL_W), .OUT_W(REG_W)) align_i (
      .raw       (word_raw),
      .wl        (wl),
      .lsb_align (fmt_q.lsb_align),
      .sign_ext  (fmt_q.sign_ext),
      .word      (word_fmt)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign push_v[c] = word_vld && (word_ch == CH_W'(c));
      assign pop_v[c]  = rd_en && (rd_ch == CH_W'(c));

      i2s_rx_chan_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(REG_W)) fifo_i (
         .clk       (clk),
         .por_n     (por_n),
         .soft_rst  (soft_rst),
         .en        (fifo_en_q[c]),
         .push      (push_v[c]),
         .push_data (word_fmt),
         .pop_req   (pop_v[c]),
         .head      (head_v[c]),
         .level     (level_v[c]),
         .ready     (ready[c])
      );
   end

   assign rd_data = head_v[rd_ch];
   assign irq     = |(ready & irq_en_q);

endmodule

// File: rtl/i2s_rx_fmt_chk.sv
`timescale 1ns/1ps
module i2s_rx_fmt_chk
   import i2s_rx_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input logic                        clk,
   input logic                        por_n,
   input logic                        soft_rst,
   input logic                        cfg_we,
   input fmt_cfg_t                    fmt_q,
   input logic [NUM_CH-1:0]           fifo_en_q,
   input logic [NUM_CH-1:0]           irq_en_q,
   input logic [NUM_CH-1:0]           push_v,
   input logic [NUM_CH-1:0]           pop_v,
   input logic [NUM_CH-1:0][CNT_W-1:0] level_v,
   input logic [NUM_CH-1:0]           ready,
   input logic                        irq
);

   localparam int READY_LEVEL = DEPTH - 1;

   // R12
   soft_keep_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst && !cfg_we) |=> ($stable(fmt_q) && $stable(fifo_en_q) && $stable(irq_en_q)));

   // R12
   soft_clr_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> (ready == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R9
      single_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
         (!fifo_en_q[c] && push_v[c] && !soft_rst && !cfg_we) |=> ready[c]);

      // R8
      fill_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
         (fifo_en_q[c] && level_v[c] == CNT_W'(READY_LEVEL - 1) && push_v[c] && !pop_v[c]
          && !soft_rst && !cfg_we) |=> ready[c]);

      // R8
      no_overflow_chk: assert property (@(posedge clk) disable iff (!por_n)
         (fifo_en_q[c] && level_v[c] == CNT_W'(DEPTH) && !pop_v[c] && !soft_rst && !cfg_we)
         |=> (level_v[c] == CNT_W'(DEPTH)));

      // R10
      read_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
         (fifo_en_q[c] && level_v[c] == CNT_W'(READY_LEVEL) && pop_v[c] && !push_v[c]
          && !soft_rst && !cfg_we) |=> !ready[c]);

      // R11
      irq_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
         ($rose(ready[c]) && irq_en_q[c]) |-> irq);
   end

endmodule

bind i2s_rx_fmt i2s_rx_fmt_chk #(.NUM_CH(NUM_CH), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .por_n     (por_n),
   .soft_rst  (soft_rst),
   .cfg_we    (cfg_we),
   .fmt_q     (fmt_q),
   .fifo_en_q (fifo_en_q),
   .irq_en_q  (irq_en_q),
   .push_v    (push_v),
   .pop_v     (pop_v),
   .level_v   (level_v),
   .ready     (ready),
   .irq       (irq)
);

// File: tb/i2s_rx_fmt_tb_top.sv
`timescale 1ns/1ps
module i2s_rx_fmt_tb_top;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_wl_code = '0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_lsb_align = 1'b0;
   logic        cfg_sign_ext = 1'b0;
   logic [1:0]  cfg_fifo_en = '0;
   logic [1:0]  cfg_irq_en = '0;
   logic        ws = 1'b0;
   logic        sd = 1'b0;
   logic        rd_en = 1'b0;
   logic        rd_ch = 1'b0;
   logic [31:0] rd_data;
   logic [1:0]  ready;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   i2s_rx_fmt dut_i (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
      .cfg_wl_code(cfg_wl_code), .cfg_lsb_first(cfg_lsb_first),
      .cfg_lsb_align(cfg_lsb_align), .cfg_sign_ext(cfg_sign_ext),
      .cfg_fifo_en(cfg_fifo_en), .cfg_irq_en(cfg_irq_en),
      .ws(ws), .sd(sd), .rd_en(rd_en), .rd_ch(rd_ch),
      .rd_data(rd_data), .ready(ready), .irq(irq)
   );

   // {code[2:0], lsb_first, lsb_align, sign_ext, pattern[23:0], expected[31:0]}
   // The pattern is sent starting from its bit W-1.
   localparam logic [61:0] VECS [12] = '{
      {3'd0, 1'b0, 1'b1, 1'b0, 24'h0000A5, 32'h000000A5},  // R1 R5
      {3'd0, 1'b0, 1'b1, 1'b1, 24'h0000A5, 32'hFFFFFFA5},  // R6
      {3'd0, 1'b1, 1'b1, 1'b1, 24'h000001, 32'hFFFFFF80},  // R2 R6
      {3'd0, 1'b0, 1'b0, 1'b1, 24'h0000A5, 32'h0000A500},  // R4 R6
      {3'd2, 1'b0, 1'b0, 1'b0, 24'h000ABC, 32'h0000ABC0},  // R4
      {3'd3, 1'b0, 1'b0, 1'b0, 24'h001234, 32'h12340000},  // R3
      {3'd7, 1'b0, 1'b0, 1'b1, 24'h800001, 32'h80000100},  // R3 R6
      {3'd7, 1'b0, 1'b1, 1'b1, 24'h800001, 32'hFF800001},  // R6
      {3'd5, 1'b1, 1'b1, 1'b0, 24'h000001, 32'h00080000},  // R2 R5
      {3'd4, 1'b0, 1'b0, 1'b0, 24'h03FFFF, 32'hFFFFC000},  // R3
      {3'd1, 1'b0, 1'b1, 1'b1, 24'h000200, 32'hFFFFFE00},  // R1 R6
      {3'd6, 1'b1, 1'b0, 1'b0, 24'h000003, 32'hC0000000}   // R2 R3
   };

   function automatic int wlen(input logic [2:0] code);
      case (code)
         3'd0: return 8;
         3'd1: return 10;
         3'd2: return 12;
         3'd3: return 16;
         3'd4: return 18;
         3'd5: return 20;
         3'd6: return 22;
         default: return 24;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2:0] code, input logic lf, input logic la,
                            input logic se, input logic [1:0] fe, input logic [1:0] ie);
      @(negedge clk);
      cfg_wl_code = code; cfg_lsb_first = lf; cfg_lsb_align = la;
      cfg_sign_ext = se; cfg_fifo_en = fe; cfg_irq_en = ie; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_soft_reset();
      @(negedge clk);
      ws = 1'b0; sd = 1'b0; soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
   endtask

   // Sends one word on channel ch, then 'extra' trailing bits of 1.
   // Returns at the falling edge after the word has been pushed.
   task automatic send_word(input logic ch, input int w, input logic [23:0] pat, input int extra);
      if (ws == ch) begin
         @(negedge clk);
         ws = ~ch; sd = 1'b0;
      end
      for (int i = w - 1; i >= 0; i--) begin
         @(negedge clk);
         ws = ch; sd = pat[i];
      end
      for (int i = 0; i < extra; i++) begin
         @(negedge clk);
         sd = 1'b1;
      end
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pop_word(input logic ch, output logic [31:0] d);
      @(negedge clk);
      rd_ch = ch;
      #1;
      d = rd_data;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      logic [61:0] v;

      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R12 R10 R11: reset state
      check(ready == 2'b00, "R12 ready after power-on", 32'(ready), 32'h0);
      check(irq == 1'b0, "R11 irq after power-on", 32'(irq), 32'h0);
      check(rd_data == 32'h0, "R10 empty read data", rd_data, 32'h0);

      // Vector table: formatting (R1..R6), FIFO disabled, channel 0
      for (int i = 0; i < 12; i++) begin
         v = VECS[i];
         write_cfg(v[61:59], v[58], v[57], v[56], 2'b00, 2'b01);
         do_soft_reset();
         send_word(1'b0, wlen(v[61:59]), v[55:32], 0);
         check(ready == 2'b01, $sformatf("R9 ready after vector %0d", i), 32'(ready), 32'h1);
         pop_word(1'b0, d);
         check(d == v[31:0], $sformatf("R1/R2/R3/R4/R5/R6 vector %0d", i), d, v[31:0]);
         check(ready == 2'b00, $sformatf("R10 ready cleared vector %0d", i), 32'(ready), 32'h0);
      end

      // R8 R10: FIFO enabled, threshold, overflow, ordered reads
      write_cfg(3'd0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b01);
      do_soft_reset();
      for (int k = 1; k <= 14; k++) send_word(1'b0, 8, 24'(k), 0);
      check(ready[0] == 1'b0, "R8 not ready at 14", 32'(ready), 32'h0);
      send_word(1'b0, 8, 24'd15, 0);
      check(ready[0] == 1'b1, "R8 ready at 15", 32'(ready), 32'h1);
      check(irq == 1'b1, "R11 irq at 15", 32'(irq), 32'h1);
      send_word(1'b0, 8, 24'd16, 0);
      send_word(1'b0, 8, 24'd17, 0);
      pop_word(1'b0, d);
      check(d == 32'd1, "R10 first read oldest", d, 32'd1);
      check(ready[0] == 1'b1, "R10 still ready at 15", 32'(ready), 32'h1);
      pop_word(1'b0, d);
      check(d == 32'd2, "R10 second read", d, 32'd2);
      check(ready[0] == 1'b0, "R10 ready cleared below 15", 32'(ready), 32'h0);
      check(irq == 1'b0, "R11 irq cleared", 32'(irq), 32'h0);
      for (int k = 3; k <= 16; k++) begin
         pop_word(1'b0, d);
         check(d == 32'(k), "R8 ordered read", d, 32'(k));
      end
      check(rd_data == 32'h0, "R8 word beyond depth dropped", rd_data, 32'h0);

      // R9: FIFO disabled, newer word replaces unread one
      write_cfg(3'd0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b11);
      do_soft_reset();
      send_word(1'b0, 8, 24'h11, 0);
      send_word(1'b0, 8, 24'h22, 0);
      pop_word(1'b0, d);
      check(d == 32'h22, "R9 replaced word", d, 32'h22);
      check(rd_data == 32'h0, "R9 single entry", rd_data, 32'h0);

      // R7: channel 1, trailing bits ignored
      send_word(1'b1, 8, 24'h5A, 4);
      check(ready == 2'b10, "R7 channel one ready", 32'(ready), 32'h2);
      check(irq == 1'b1, "R11 irq channel one", 32'(irq), 32'h1);
      pop_word(1'b1, d);
      check(d == 32'h5A, "R7 channel one data", d, 32'h5A);
      check(rd_data == 32'h0 && ready == 2'b00, "R7 trailing bits ignored", rd_data, 32'h0);

      // R7: partial word abandoned on ws change
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         ws = 1'b0; sd = 1'b1;
      end
      send_word(1'b1, 8, 24'h3C, 0);
      check(ready == 2'b10, "R7 partial word dropped", 32'(ready), 32'h2);
      pop_word(1'b1, d);
      check(d == 32'h3C, "R7 word after abandon", d, 32'h3C);

      // R11: interrupt masked
      write_cfg(3'd0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00);
      do_soft_reset();
      send_word(1'b0, 8, 24'h01, 0);
      check(ready == 2'b01, "R11 ready while masked", 32'(ready), 32'h1);
      check(irq == 1'b0, "R11 irq masked", 32'(irq), 32'h0);

      // R12: soft reset keeps configuration and empties the FIFO
      write_cfg(3'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b01);
      do_soft_reset();
      check(ready == 2'b00 && rd_data == 32'h0, "R12 soft reset empties", rd_data, 32'h0);
      send_word(1'b0, 8, 24'h80, 0);
      pop_word(1'b0, d);
      check(d == 32'hFFFFFF80, "R12 config kept over soft reset", d, 32'hFFFFFF80);

      // R12: power-on reset clears configuration (8 bits, msb first, top aligned)
      send_word(1'b0, 8, 24'h44, 0);
      @(negedge clk);
      por_n = 1'b0; ws = 1'b0; sd = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      check(ready == 2'b00 && rd_data == 32'h0, "R12 power-on empties", rd_data, 32'h0);
      send_word(1'b0, 8, 24'h12, 0);
      check(ready == 2'b01, "R12 fifo disabled after power-on", 32'(ready), 32'h1);
      check(irq == 1'b0, "R12 irq enable cleared", 32'(irq), 32'h0);
      pop_word(1'b0, d);
      check(d == 32'h00001200, "R12 config cleared by power-on", d, 32'h00001200);

      done = 1;
      finish_run();
   end

endmodule